// File: doc/BRIEF.md
# SIMD pairwise widening adder

This block executes one vector instruction: it sums each neighbouring pair of elements in a source vector and writes the sums as elements of twice the source width. Every result lane is therefore the widened sum of two inputs, and there are half as many result lanes as input lanes. A 32-bit instruction word supplies all the controls. It selects the element size (8, 16 or 32 bits), signed or unsigned arithmetic, and a 64-bit or 128-bit vector length. The block pulls the 5-bit destination and source register numbers out of the word and hands them on with the result.

A register file, not part of this block, reads the operand and presents it on `src_vec` in the same cycle as `in_valid`. An accepted word is one whose fixed opcode bits match. For such a word the block registers the sum and the register numbers and raises `out_valid` for one cycle on the next clock edge. An encoding that cannot execute raises `out_undef` together with `out_valid`, and the held result vector stays as it was. A word whose fixed bits do not match is ignored.

The control is a three-state machine:
- `ST_IDLE`: no result is being presented.
- `ST_DONE`: a valid result is on the outputs.
- `ST_TRAP`: an undefined encoding was accepted.

From any state the machine moves as follows on each clock edge:
- An accepted, defined word moves it to `ST_DONE`.
- An accepted, undefined word moves it to `ST_TRAP`.
- Any other input returns it to `ST_IDLE`.

Top module: `pwa_pairwise_widen`

## Requirements
- R1: Result lane i equals source element 2i plus source element 2i+1, and each lane is twice as wide as a source element.
- R2: Instruction bits 19:18 give the element size: 00 means 8 bits, 01 means 16 bits and 10 means 32 bits.
- R3: Instruction bit 7 sets the arithmetic. When it is 0, operands are sign-extended before the add; when it is 1, they are zero-extended.
- R4: Instruction bit 6 sets the length. When it is 0, only source bits 63:0 are used and result bits 127:64 are zero. When it is 1, all 128 bits are used.
- R5: The destination register number is {bit 22, bits 15:12} and the source register number is {bit 5, bits 3:0}.
- R6: A word is accepted only when all of these hold: bits 31:23 are all ones, bits 21:20 are 11, bits 17:16 are 00, bits 11:8 are 0010, and bit 4 is 0. Any other word produces no `out_valid`, and `out_vec` does not change.
- R7: An accepted word with size 11 raises `out_undef`, and `out_vec` keeps its previous value.
- R8: An accepted word with bit 6 set raises `out_undef` and leaves `out_vec` unchanged if either register number is odd.
- R9: `out_valid` rises exactly one cycle after an accepted `in_valid` and lasts one cycle per accepted word.
- R10: Sums never overflow, including at the most negative and the largest unsigned operands.
- R11: After reset, `out_valid`, `out_undef`, `out_vec` and both register numbers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction word and operand are presented |
| instr | input | 32 | Instruction word |
| src_vec | input | VEC_W (128) | Source operand vector |
| out_valid | output | 1 | Result presented this cycle |
| out_undef | output | 1 | Presented instruction was undefined |
| out_dst_reg | output | 5 | Destination register number |
| out_src_reg | output | 5 | Source register number |
| out_vec | output | VEC_W (128) | Widened pairwise sums |

## Verification
The bench builds the block with the default vector width of 128. At that width both the 64-bit and the 128-bit lengths can be exercised, along with the masking of the upper result half. Random words cover every size, sign and length combination, as well as reserved sizes and odd register numbers in 128-bit mode. A bench model checks each result. Directed cases drive the extreme operands of every size, corrupt each fixed field in turn, and check that undefined or ignored words leave the held vector untouched.

// File: rtl/pwa_pkg.sv
package pwa_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned REG_W   = 5;

    typedef enum logic [1:0] {
        ESZ_B8  = 2'b00,
        ESZ_B16 = 2'b01,
        ESZ_B32 = 2'b10,
        ESZ_RSV = 2'b11
    } esz_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_DONE = 2'b01,
        ST_TRAP = 2'b10
    } ctl_state_e;

    typedef struct packed {
        logic             match;
        logic             undef;
        esz_e             esz;
        logic             uns;
        logic             quad;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src;
    } dec_t;

endpackage

// File: rtl/pwa_decode.sv
module pwa_decode
    import pwa_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    // field positions
    localparam int unsigned POS_DHI  = 22;
    localparam int unsigned POS_SZ   = 18;
    localparam int unsigned POS_VD   = 12;
    localparam int unsigned POS_OP   = 7;
    localparam int unsigned POS_Q    = 6;
    localparam int unsigned POS_MHI  = 5;
    localparam int unsigned POS_VM   = 0;
    localparam int unsigned LOW_W    = REG_W - 1;

    logic fix_top, fix_mid, fix_pad, fix_grp, fix_b4;
    logic [LOW_W-1:0] vd_f, vm_f;
    esz_e sz_f;

    always_comb begin
        fix_top = &instr[31:23];
        fix_mid = (instr[21:20] == 2'b11);
        fix_pad = (instr[17:16] == 2'b00);
        fix_grp = (instr[11:8]  == 4'b0010);
        fix_b4  = ~instr[4];
        vd_f    = instr[POS_VD +: LOW_W];
        vm_f    = instr[POS_VM +: LOW_W];
        sz_f    = esz_e'(instr[POS_SZ +: 2]);

        dec.match = fix_top & fix_mid & fix_pad & fix_grp & fix_b4;
        dec.esz   = sz_f;
        dec.uns   = instr[POS_OP];
        dec.quad  = instr[POS_Q];
        dec.dst   = {instr[POS_DHI], vd_f};
        dec.src   = {instr[POS_MHI], vm_f};
        dec.undef = (sz_f == ESZ_RSV) | (instr[POS_Q] & (vd_f[0] | vm_f[0]));
    end

endmodule

// File: rtl/pwa_pair_add.sv
module pwa_pair_add
    import pwa_pkg::*;
#(
    parameter int unsigned VEC_W = 128
) (
    input  logic [VEC_W-1:0] src,
    input  esz_e             esz,
    input  logic             uns,
    input  logic             quad,
    output logic [VEC_W-1:0] res
);
    localparam int unsigned HALF_W = VEC_W / 2;
    localparam int unsigned N_SZ   = 3;

    logic [VEC_W-1:0] by_size [N_SZ];

    for (genvar gk = 0; gk < N_SZ; gk++) begin : g_sz
        localparam int unsigned EW = 8 << gk;
        localparam int unsigned NR = VEC_W / (2 * EW);
        logic [VEC_W-1:0] packed_res;
        for (genvar gi = 0; gi < NR; gi++) begin : g_lane
            logic [EW-1:0]   lo_e, hi_e;
            logic [2*EW-1:0] lo_x, hi_x;
            assign lo_e = src[(2*gi)*EW +: EW];
            assign hi_e = src[(2*gi+1)*EW +: EW];
            assign lo_x = {{EW{lo_e[EW-1] & ~uns}}, lo_e};
            assign hi_x = {{EW{hi_e[EW-1] & ~uns}}, hi_e};
            assign packed_res[gi*2*EW +: 2*EW] = lo_x + hi_x;
        end
        assign by_size[gk] = packed_res;
    end

    always_comb begin
        unique case (esz)
            ESZ_B8:  res = by_size[0];
            ESZ_B16: res = by_size[1];
            ESZ_B32: res = by_size[2];
            default: res = '0;
        endcase
        if (!quad) begin
            res[VEC_W-1:HALF_W] = '0;
        end
    end

endmodule

// File: rtl/pwa_ctrl.sv
module pwa_ctrl
    import pwa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    input  logic undef,
    output logic out_valid,
    output logic out_undef
);
    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_TRAP: begin
                if (acc) begin
                    state_d = undef ? ST_TRAP : ST_DONE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        out_valid = 1'b0;
        out_undef = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DONE: out_valid = 1'b1;
            ST_TRAP: begin
                out_valid = 1'b1;
                out_undef = 1'b1;
            end
            default: ;
        endcase
    end

    AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && undef) |=> (state_q == ST_TRAP)); // R7
    AST_IDLE_ON_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (state_q == ST_IDLE)); // R6

endmodule

// File: rtl/pwa_pairwise_widen.sv
module pwa_pairwise_widen
    import pwa_pkg::*;
#(
    parameter int unsigned VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [31:0]        instr,
    input  logic [VEC_W-1:0]   src_vec,
    output logic               out_valid,
    output logic               out_undef,
    output logic [4:0]         out_dst_reg,
    output logic [4:0]         out_src_reg,
    output logic [VEC_W-1:0]   out_vec
);
    localparam int unsigned HALF_W = VEC_W / 2;

    dec_t             dec;
    logic             acc;
    logic [VEC_W-1:0] sum_vec;

    pwa_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    pwa_pair_add #(.VEC_W(VEC_W)) u_add (
        .src  (src_vec),
        .esz  (dec.esz),
        .uns  (dec.uns),
        .quad (dec.quad),
        .res  (sum_vec)
    );

    assign acc = in_valid & dec.match;

    pwa_ctrl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .undef     (dec.undef),
        .out_valid (out_valid),
        .out_undef (out_undef)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_dst_reg <= '0;
            out_src_reg <= '0;
            out_vec     <= '0;
        end else if (acc) begin
            out_dst_reg <= dec.dst;
            out_src_reg <= dec.src;
            if (!dec.undef) begin
                out_vec <= sum_vec;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid); // R9
    AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> $stable(out_vec)); // R7
    AST_QUAD_ODD_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && instr[6] && instr[12]) |=> out_undef); // R8
    AST_DWORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !dec.undef && !instr[6]) |=> (out_vec[VEC_W-1:HALF_W] == '0)); // R4
    AST_DST_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (out_dst_reg == $past({instr[22], instr[15:12]}))); // R5
    AST_IGNORED_KEEPS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(out_vec)); // R6

endmodule

// File: tb/sim_pwa_pairwise_widen.sv
module sim_pwa_pairwise_widen;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic [VW-1:0] src_vec = '0;
    logic          out_valid, out_undef;
    logic [4:0]    out_dst_reg, out_src_reg;
    logic [VW-1:0] out_vec;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [VW-1:0] last_vec = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwa_pairwise_widen #(.VEC_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_vec(src_vec), .out_valid(out_valid), .out_undef(out_undef),
        .out_dst_reg(out_dst_reg), .out_src_reg(out_src_reg), .out_vec(out_vec)
    );

    task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit d, bit [1:0] sz, bit [3:0] vd, bit op, bit q, bit m, bit [3:0] vm);
        return {9'h1FF, d, 2'b11, sz, 2'b00, vd, 4'b0010, op, q, m, 1'b0, vm};
    endfunction

    function automatic logic [VW-1:0] ref_sum(input logic [1:0] sz, input logic uns, input logic q, input logic [VW-1:0] s);
        int ew;
        int n;
        logic [VW-1:0] r;
        ew = 8 << sz;
        n = (q ? 128 : 64) / (2 * ew);
        r = '0;
        for (int i = 0; i < n; i++) begin
            logic [VW-1:0] t;
            logic [63:0] m1, a, b, sm;
            m1 = (64'd1 << ew) - 64'd1;
            t = s >> (2 * i * ew);
            a = t[63:0] & m1;
            t = s >> ((2 * i + 1) * ew);
            b = t[63:0] & m1;
            if (!uns) begin
                if (a[ew-1]) a = a | ~m1;
                if (b[ew-1]) b = b | ~m1;
            end
            sm = a + b;
            if (ew < 32) sm = sm & ((64'd1 << (2 * ew)) - 64'd1);
            r = r | ({64'd0, sm} << (i * 2 * ew));
        end
        return r;
    endfunction

    task automatic do_op(input logic [31:0] ins, input logic [VW-1:0] sv, input string tag);
        bit matched, und;
        logic [VW-1:0] expv;
        matched = ((ins & 32'hFFB30F10) == 32'hFFB00200);
        und = (ins[19:18] == 2'b11) || (ins[6] && (ins[12] || ins[0]));
        expv = ref_sum(ins[19:18], ins[7], ins[6], sv);
        @(negedge clk);
        in_valid = 1'b1;
        instr = ins;
        src_vec = sv;
        @(negedge clk);
        in_valid = 1'b0;
        if (!matched) begin
            chk(out_valid == 1'b0, "R6 valid", {127'd0, out_valid}, '0);
            chk(out_vec == last_vec, "R6 vec", out_vec, last_vec);
        end else begin
            chk(out_valid == 1'b1, "R9 valid", {127'd0, out_valid}, 1);
            chk(out_dst_reg == {ins[22], ins[15:12]}, "R5 dst", out_dst_reg, {ins[22], ins[15:12]});
            chk(out_src_reg == {ins[5], ins[3:0]}, "R5 src", out_src_reg, {ins[5], ins[3:0]});
            if (und) begin
                chk(out_undef == 1'b1, (ins[19:18] == 2'b11) ? "R7 undef" : "R8 undef", {127'd0, out_undef}, 1);
                chk(out_vec == last_vec, (ins[19:18] == 2'b11) ? "R7 hold" : "R8 hold", out_vec, last_vec);
            end else begin
                chk(out_undef == 1'b0, {tag, " undef"}, {127'd0, out_undef}, '0);
                chk(out_vec == expv, tag, out_vec, expv);
                last_vec = expv;
            end
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 pulse", {127'd0, out_valid}, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_undef == 0, "R11 flags", {126'd0, out_valid, out_undef}, '0);
        chk(out_vec == '0 && out_dst_reg == 0 && out_src_reg == 0, "R11 data", out_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: each element size on a counting pattern
        v = 128'h0F0E0D0C0B0A09080706050403020100;
        do_op(mk(0, 2'b00, 4'h2, 1, 1, 0, 4'h4), v, "R2 b8");
        do_op(mk(0, 2'b01, 4'h2, 1, 1, 0, 4'h4), v, "R2 b16");
        do_op(mk(0, 2'b10, 4'h2, 1, 1, 0, 4'h4), v, "R2 b32");
        // R3: all ones, signed vs unsigned
        v = '1;
        for (int s = 0; s < 3; s++) begin
            do_op(mk(0, s[1:0], 4'h0, 0, 1, 0, 4'h0), v, "R3 signed");
            do_op(mk(0, s[1:0], 4'h0, 1, 1, 0, 4'h0), v, "R3 unsigned");
        end
        chk(out_vec == {2{64'h00000001FFFFFFFE}}, "R3 u32 value", out_vec, {2{64'h00000001FFFFFFFE}});
        // R10: most negative pairs
        do_op(mk(1, 2'b00, 4'h6, 0, 1, 1, 4'h8), {16{8'h80}}, "R10 s8");
        chk(out_vec == {8{16'hFF00}}, "R10 s8 value", out_vec, {8{16'hFF00}});
        do_op(mk(1, 2'b01, 4'h6, 0, 1, 1, 4'h8), {8{16'h8000}}, "R10 s16");
        do_op(mk(1, 2'b10, 4'h6, 0, 1, 1, 4'h8), {4{32'h80000000}}, "R10 s32");
        chk(out_vec == {2{64'hFFFFFFFF00000000}}, "R10 s32 value", out_vec, {2{64'hFFFFFFFF00000000}});
        do_op(mk(1, 2'b10, 4'h6, 1, 1, 1, 4'h8), {4{32'hFFFFFFFF}}, "R10 u32");
        // R4: doubleword ignores upper source half
        v = {64'hDEADBEEFCAFEF00D, 64'h0102030405060708};
        do_op(mk(0, 2'b00, 4'h3, 1, 0, 0, 4'h5), v, "R4 dword");
        chk(out_vec[127:64] == 64'd0, "R4 upper zero", out_vec, {64'd0, out_vec[63:0]});
        do_op(mk(0, 2'b00, 4'h2, 1, 1, 0, 4'h6), v, "R4 qword");
        // R5: register numbers with high bits set, doubleword odd numbers legal
        do_op(mk(1, 2'b01, 4'hF, 0, 0, 1, 4'hB), v, "R5 regs");
        // R7 / R8
        do_op(mk(0, 2'b11, 4'h2, 0, 1, 0, 4'h2), v, "R7");
        do_op(mk(0, 2'b11, 4'h2, 0, 0, 0, 4'h2), v, "R7");
        do_op(mk(0, 2'b00, 4'h3, 0, 1, 0, 4'h2), v, "R8");
        do_op(mk(0, 2'b00, 4'h2, 0, 1, 0, 4'h9), v, "R8");
        // R6: each fixed field corrupted
        do_op(mk(0, 2'b00, 4'h2, 0, 1, 0, 4'h4) | 32'h10, v, "R6");
        do_op(mk(0, 2'b00, 4'h2, 0, 1, 0, 4'h4) ^ 32'h100, v, "R6");
        do_op(mk(0, 2'b00, 4'h2, 0, 1, 0, 4'h4) | 32'h20000, v, "R6");
        do_op(mk(0, 2'b00, 4'h2, 0, 1, 0, 4'h4) & ~32'h80000000, v, "R6");
        do_op(mk(0, 2'b00, 4'h2, 0, 1, 0, 4'h4) & ~32'h00100000, v, "R6");

        // R1: random coverage of all sizes, signs and lengths
        for (int k = 0; k < 600; k++) begin
            logic [31:0] w;
            logic [VW-1:0] rv;
            rv = {$urandom, $urandom, $urandom, $urandom};
            w = mk(1'($urandom), 2'($urandom), 4'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), 4'($urandom));
            if (($urandom % 10) == 0) w = w ^ (32'h1 << ($urandom % 32));
            do_op(w, rv, "R1 random");
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule